// File: doc/BRIEF.md
# Half-Word Flash to Word Fetch Adapter

This block lets a processor read instructions and data out of a flash array whose read port is only 16 bits wide. Each request asks for a half-word or a full 32-bit word. A full word is built from two back-to-back half-word reads: the lower half at the word address and the upper half at the word address plus two. The two halves are packed little-endian.

A request is held on the request port until the block raises `rsp_ready` for one cycle. The block adds a decode cycle before the flash access when the address breaks the sequential stream, and also for any data read. A sequential half-word instruction fetch costs one flash cycle. A word request whose byte address is not a multiple of four gets an error response and never reaches the flash. Each response carries the number of wait cycles the request spent, which makes every latency case visible at the ports.

The flash port is a synchronous read. The address is presented with `fl_en` in one cycle, and `fl_rdata` holds the half-word from the following cycle until the next enabled read.

Top module: `hw_fetch_adapter`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released before any request, `rsp_ready` and `fl_en` are 0. An asserted reset abandons any request in progress.
- R2: A sequential half-word instruction fetch makes exactly one flash read, at the request address with bit 0 cleared. It responds with 1 wait cycle and returns the half-word zero-extended in `rsp_data[15:0]`.
- R3: A word request makes exactly two flash reads. The first is at the request address and the second is at that address plus 2, in the next cycle. The response is `{second half, first half}`.
- R4: A request with `req_seq`=0 gets one decode cycle, with `fl_en` low, before its first flash read. This adds 1 to its wait count.
- R5: A data read (`req_data`=1) always gets the decode cycle. A sequential word data read therefore responds with 3 wait cycles, and a sequential half-word data read with 2.
- R6: A word request with `req_addr[1:0]` not equal to 00 makes no flash read. It responds in the cycle after acceptance with `rsp_err`=1, `rsp_waits`=0 and `rsp_data`=0. A half-word request never sets `rsp_err`.
- R7: `rsp_ready` is high for exactly one cycle per request. If `req_valid` stays high, the next request is accepted in the cycle after `rsp_ready`. A held sequential half-word fetch therefore completes once every 3 cycles.
- R8: `rsp_waits` equals the decode cycles plus the flash cycles of the request. The bench also sees `rsp_ready` exactly `rsp_waits`+1 rising edges after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; held until `rsp_ready` |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wide | input | 1 | 1 = 32-bit word, 0 = 16-bit half-word |
| req_seq | input | 1 | 1 = follows the previous address, 0 = new address |
| req_data | input | 1 | 1 = data read, 0 = instruction fetch |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_data | output | 2*HALF_W | Assembled read data, valid with `rsp_ready` |
| rsp_err | output | 1 | Misaligned word request, valid with `rsp_ready` |
| rsp_waits | output | WAIT_W | Wait cycles spent, valid with `rsp_ready` |
| fl_en | output | 1 | Flash read enable |
| fl_addr | output | ADDR_W | Flash half-word byte address |
| fl_rdata | input | HALF_W | Flash read data, one cycle after `fl_en` |

## Verification
The stimulus table crosses width (half-word and word) with stream position (sequential and new address) and access kind (instruction and data). This tells apart the 1, 2 and 3 wait-cycle paths, and the extra decode cycle shows up whether it comes from a branch or from a data read. A half-word request with bit 0 set checks that the low bit is cleared. Word requests offset by one and by two bytes check that the error path skips the flash. A word at the top of the address space checks that the second read address does not carry into a wrong location. Directed tests hold `req_valid` high to measure the back-to-back rate, and assert reset in the middle of a word read.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEC,
    S_LO,
    S_HI,
    S_RESP
  } fa_state_e;
endpackage

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import fa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic              req_seq,
  input  logic              req_data,
  output logic              fl_en,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              lo_en,
  output logic              wide_q,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [WAIT_W-1:0] rsp_waits
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  fa_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wide_d, err_q, err_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              accept, misaligned, need_dec;

  assign accept     = (state_q == S_IDLE) && req_valid;
  assign misaligned = req_wide && (req_addr[1:0] != 2'b00);
  assign need_dec   = !req_seq || req_data;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wide_d  = wide_q;
    err_d   = err_q;
    wait_d  = wait_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        addr_d  = {req_addr[ADDR_W-1:1], 1'b0};
        wide_d  = req_wide;
        err_d   = misaligned;
        wait_d  = '0;
        state_d = misaligned ? S_RESP : (need_dec ? S_DEC : S_LO);
      end
      S_DEC: begin
        wait_d  = wait_q + 1'b1;
        state_d = S_LO;
      end
      S_LO: begin
        wait_d  = wait_q + 1'b1;
        state_d = wide_q ? S_HI : S_RESP;
      end
      S_HI: begin
        wait_d  = wait_q + 1'b1;
        state_d = S_RESP;
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wide_q  <= wide_d;
      err_q   <= err_d;
      wait_q  <= wait_d;
    end
  end

  assign fl_en     = (state_q == S_LO) || (state_q == S_HI);
  assign fl_addr   = (state_q == S_HI) ? addr_q + HALF_STEP : addr_q;
  assign lo_en     = (state_q == S_HI);
  assign rsp_ready = (state_q == S_RESP);
  assign rsp_err   = rsp_ready && err_q;
  assign rsp_waits = rsp_ready ? wait_q : '0;

  // R6: a misaligned word goes straight to the response, no flash access
  assert_err_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misaligned) |=> (rsp_ready && rsp_err && !fl_en));

  // R4 / R5: decode cycle keeps the flash idle
  assert_decode_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !misaligned && need_dec) |=> (!fl_en && !rsp_ready));

  // R3: upper half read follows at address plus two
  assert_hi_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && (state_q == S_LO) && wide_q) |=> (fl_en && (fl_addr == $past(fl_addr) + HALF_STEP)));
endmodule

// File: rtl/fa_assemble.sv
module fa_assemble #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_en,
  input  logic                wide_q,
  input  logic                rsp_ready,
  input  logic                rsp_err,
  input  logic [HALF_W-1:0]   fl_rdata,
  output logic [2*HALF_W-1:0] rsp_data
);
  logic [HALF_W-1:0] lo_q, lo_d;

  always_comb lo_d = lo_en ? fl_rdata : lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  always_comb begin
    rsp_data = '0;
    if (rsp_ready && !rsp_err)
      rsp_data = wide_q ? {fl_rdata, lo_q} : {{HALF_W{1'b0}}, fl_rdata};
  end

  // R6: an error response carries no data
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_data == '0));
endmodule

// File: rtl/hw_fetch_adapter.sv
module hw_fetch_adapter #(
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_wide,
  input  logic                req_seq,
  input  logic                req_data,
  output logic                rsp_ready,
  output logic [2*HALF_W-1:0] rsp_data,
  output logic                rsp_err,
  output logic [WAIT_W-1:0]   rsp_waits,
  output logic                fl_en,
  output logic [ADDR_W-1:0]   fl_addr,
  input  logic [HALF_W-1:0]   fl_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       lo_en, wide_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  fa_ctrl #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_wide  (req_wide),
    .req_seq   (req_seq),
    .req_data  (req_data),
    .fl_en     (fl_en),
    .fl_addr   (fl_addr),
    .lo_en     (lo_en),
    .wide_q    (wide_q),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .rsp_waits (rsp_waits)
  );

  fa_assemble #(.HALF_W(HALF_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .lo_en     (lo_en),
    .wide_q    (wide_q),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .fl_rdata  (fl_rdata),
    .rsp_data  (rsp_data)
  );

  // R7: response strobe lasts one cycle
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_ready |=> !rsp_ready);

  // R8: a good response always spent at least one flash cycle
  assert_waits_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_ready && !rsp_err) |-> (rsp_waits != '0));

  // R1: flash and response are quiet while the block is in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_s |-> (!fl_en && !rsp_ready));
endmodule

// File: tb/tb_hw_fetch_adapter.sv
`timescale 1ns/1ps
module tb_hw_fetch_adapter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_wide, req_seq, req_data;
  logic [15:0] req_addr;
  logic        rsp_ready, rsp_err, fl_en;
  logic [31:0] rsp_data;
  logic [1:0]  rsp_waits;
  logic [15:0] fl_addr, fl_rdata;

  int n_chk = 0, n_bad = 0;
  int n_rd;
  logic [15:0] rd_addr [2];

  always #2.5 clk = ~clk;

  hw_fetch_adapter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wide(req_wide), .req_seq(req_seq), .req_data(req_data),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .rsp_waits(rsp_waits), .fl_en(fl_en), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  function automatic logic [15:0] fmem(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h13};
  endfunction

  // flash model: synchronous read, data held until the next enabled read
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_rdata <= 16'h0;
    else if (fl_en) begin
      fl_rdata <= fmem(fl_addr);
      if (n_rd < 2) rd_addr[n_rd] <= fl_addr;
      n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic        wide;
    logic        seq;
    logic        dat;
    logic        err;
    logic [1:0]  waits;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1},  // R2
    '{16'h0103, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1},  // R2 bit0 cleared
    '{16'h0200, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'd2},  // R3
    '{16'h0204, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd2},  // R4
    '{16'h0106, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1},  // R4
    '{16'h0300, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 2'd2},  // R5
    '{16'h0302, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd1},  // R5
    '{16'h0302, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0},  // R6
    '{16'h0301, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0},  // R6
    '{16'h0301, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1},  // R6 half-word never errs
    '{16'hFFFC, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'd2}   // R3 top of space
  };

  // expects to be called at a negedge, returns at a negedge with the block idle
  task automatic run(input vec_t v, input int idx);
    int cyc = 0;
    logic [15:0] a0;
    logic [31:0] exp_d;
    req_addr = v.addr; req_wide = v.wide; req_seq = v.seq; req_data = v.dat;
    req_valid = 1'b1;
    n_rd = 0;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (rsp_ready || cyc > 20) break;
    end
    a0 = {v.addr[15:1], 1'b0};
    if (v.err) exp_d = 32'h0;
    else if (v.wide) exp_d = {fmem(a0 + 16'd2), fmem(a0)};
    else exp_d = {16'h0, fmem(a0)};
    chk($sformatf("R8 latency vec%0d", idx), cyc, v.waits + 1);
    chk($sformatf("R8 waits vec%0d", idx), rsp_waits, v.waits);
    chk($sformatf("R6 err vec%0d", idx), rsp_err, v.err);
    chk($sformatf("R3 data vec%0d", idx), rsp_data, exp_d);
    req_valid = 1'b0;
    @(negedge clk);
    chk($sformatf("R7 pulse vec%0d", idx), rsp_ready, 1'b0);
    chk($sformatf("R2 reads vec%0d", idx), n_rd, v.nrd);
    if (v.nrd >= 1) chk($sformatf("R2 addr0 vec%0d", idx), rd_addr[0], a0);
    if (v.nrd == 2) chk($sformatf("R3 addr1 vec%0d", idx), rd_addr[1], a0 + 16'd2);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rdy_cnt, prev_rdy, dbl;
    n_rd = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_wide = 1'b0; req_seq = 1'b1; req_data = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", rsp_ready, 1'b0);
    chk("R1 flash in reset", fl_en, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", rsp_ready, 1'b0);
    chk("R1 flash after reset", fl_en, 1'b0);

    for (int i = 0; i < NV; i++) run(VECS[i], i);

    // R7: held request, sequential half-word, one response every 3 cycles
    req_addr = 16'h0400; req_wide = 1'b0; req_seq = 1'b1; req_data = 1'b0;
    req_valid = 1'b1;
    rdy_cnt = 0; prev_rdy = 0; dbl = 0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); @(negedge clk);
      if (rsp_ready) begin rdy_cnt++; if (prev_rdy != 0) dbl++; end
      prev_rdy = rsp_ready;
    end
    req_valid = 1'b0;
    chk("R7 back-to-back count", rdy_cnt, 4);
    chk("R7 no double strobe", dbl, 0);
    repeat (3) @(negedge clk);

    // R1: reset in the middle of a word read abandons it
    req_addr = 16'h0500; req_wide = 1'b1; req_seq = 1'b0; req_data = 1'b1;
    req_valid = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R1 mid-read ready", rsp_ready, 1'b0);
    chk("R1 mid-read flash", fl_en, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 no stray response", rsp_ready, 1'b0);
    run(VECS[2], 99);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule